// File: doc/BRIEF.md
# SMBus Indexed Block Configuration Target

This block is a serial-bus target that exposes a small file of 8-bit configuration registers to a host. Every access is indexed. On a write the host sends the write address, a starting register index and a byte count, and then that many data bytes. On a read the host sends the write address and a starting index, then a repeated start and the read address. The target first returns a byte count, then streams registers starting at the index. The byte count comes from a count register that sits inside the register map.

SCL and SDA arrive as raw bus levels. They are oversampled on the system clock through a two-flop synchroniser, and start, stop and clock-edge events are detected from the synchronised lines. The target drives SDA only through an open-drain enable, and it changes that enable only while SCL is low. The current register contents are presented in parallel on a flat configuration bus for the logic that uses them. One status bit is supplied from outside and reads back in place of a stored bit.

Top module: `smb_cfg_target`

## Requirements
- R1: While reset is asserted and after it is released, the SDA enable is low. Register 8 (the count register) resets to 0x0F and every other register resets to 0x00.
- R2: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged. Any other address byte is not acknowledged, and the target then ignores all bus activity until the next start, including bytes that follow in the same transfer.
- R3: A write transfer has the form start, 0xD2, index N, count X, then data bytes. Every byte is acknowledged, and the data bytes are stored in registers N, N+1, and so on, with the index advancing after each byte.
- R4: Once X data bytes have been written, a further data byte in the same transfer is not acknowledged and is not stored.
- R5: A read transfer has the form start, 0xD2, index N, repeated start, 0xD3. The first byte returned is the current value of register 8. The bytes after it are registers N, N+1, and so on, as long as the host acknowledges.
- R6: Writing register 8 changes the count byte that later reads return first.
- R7: When the host answers a read byte with a not-acknowledge, the target releases SDA and sends nothing more until the next start.
- R8: Indices 15 and above read as 0x00. Data written to them is acknowledged but changes no register.
- R9: Bit 5 of register 10 reads as the status input and cannot be written. Bit 7 of register 14 always reads 0 and cannot be written.
- R10: The SDA enable changes only while the synchronised SCL is low.
- R11: A stop, or a start, in the middle of a transfer aborts it. Bytes already acknowledged stay written, a partial byte is discarded, and a start begins a fresh address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad (wired bus value) |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| status_i | input | 1 | External status bit shown in register 10 bit 5 |
| cfg_o | output | 120 | Readable value of all registers, register k in bits 8k+7..8k |

## Verification
The hardest situation to reach is an abort that arrives part-way through a byte, after earlier bytes of the same transfer have already been acknowledged. The bench's host model clocks out only four bits of a data byte and then issues a stop. It then checks through the configuration bus that the earlier byte is stored and the interrupted register is untouched. A second transfer issues a repeated start immediately after an acknowledged data byte and checks that the new address phase is accepted. The read-only bits are brought out by reading them back while the status input is held at each level in turn.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } state_e;

  typedef enum logic [1:0] {
    B_ADDR,
    B_INDEX,
    B_COUNT,
    B_DATA
  } role_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // extra stage holds previous synchronised value
  logic [SYNC_STAGES:0] scl_pipe, sda_pipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
    end
  end

  logic scl_prev, sda_prev;
  assign scl_o    = scl_pipe[SYNC_STAGES-1];
  assign sda_o    = sda_pipe[SYNC_STAGES-1];
  assign scl_prev = scl_pipe[SYNC_STAGES];
  assign sda_prev = sda_pipe[SYNC_STAGES];

  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs #(
  parameter int          NUM_REGS = 15,
  parameter int          ADDR_W   = 8,
  parameter int          CNT_IDX  = 8,
  parameter logic [7:0]  CNT_RST  = 8'h0F,
  parameter int          STAT_IDX = 10,
  parameter int          STAT_BIT = 5,
  parameter int          RSV_IDX  = 14,
  parameter int          RSV_BIT  = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     waddr_i,
  input  logic [7:0]            wdata_i,
  input  logic [ADDR_W-1:0]     raddr_i,
  input  logic                  status_i,
  output logic [7:0]            rdata_o,
  output logic [7:0]            cnt_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  logic [7:0] view [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] WMASK = (g == STAT_IDX) ? ~(8'h01 << STAT_BIT) :
                                   (g == RSV_IDX)  ? ~(8'h01 << RSV_BIT)  : 8'hFF;
    localparam logic [7:0] RST   = (g == CNT_IDX) ? CNT_RST : 8'h00;
    logic [7:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q <= RST;
      else if (we_i && waddr_i == ADDR_W'(g))      q <= wdata_i & WMASK;
    end

    if (g == STAT_IDX) begin : g_stat
      assign view[g] = (q & WMASK) | (status_i ? (8'h01 << STAT_BIT) : 8'h00);
    end else begin : g_plain
      assign view[g] = q;
    end
    assign cfg_o[g*8 +: 8] = view[g];
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (raddr_i == ADDR_W'(i)) rdata_o = view[i];
  end

  assign cnt_o = view[CNT_IDX];
endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 15,
  parameter int         CNT_IDX     = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        CFG_W       = NUM_REGS * 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             status_i,
  output logic [CFG_W-1:0] cfg_o
);
  localparam int IDX_W = 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_s, stop_s;

  smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_s), .stop_o(stop_s)
  );

  state_e           state_q;
  role_e            role_q;
  logic [7:0]       shreg_q;
  logic [3:0]       bit_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       wcnt_q;
  logic             rd_q;
  logic             sda_oe_q;

  logic [7:0] rdata, cnt_val;
  logic       rx_done, ack, wr_en;

  assign rx_done = (state_q == ST_RX) && scl_fall && (bit_q == 4'd8) && !start_s && !stop_s;

  always_comb begin
    unique case (role_q)
      B_ADDR:  ack = (shreg_q[7:1] == DEV_ADDR);
      B_DATA:  ack = (wcnt_q != 8'd0);
      default: ack = 1'b1;
    endcase
  end

  assign wr_en = rx_done && (role_q == B_DATA) && (wcnt_q != 8'd0);

  smb_cfg_regs #(.NUM_REGS(NUM_REGS), .ADDR_W(IDX_W), .CNT_IDX(CNT_IDX)) u_regs (
    .clk_i, .rst_ni,
    .we_i(wr_en), .waddr_i(idx_q), .wdata_i(shreg_q),
    .raddr_i(idx_q), .status_i,
    .rdata_o(rdata), .cnt_o(cnt_val), .cfg_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      role_q  <= B_ADDR;
      shreg_q <= 8'h00;
      bit_q   <= 4'd0;
      idx_q   <= '0;
      wcnt_q  <= 8'd0;
      rd_q    <= 1'b0;
    end else if (start_s) begin
      state_q <= ST_RX;
      role_q  <= B_ADDR;
      bit_q   <= 4'd0;
    end else if (stop_s) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise && bit_q != 4'd8) begin
            shreg_q <= {shreg_q[6:0], sda_s};
            bit_q   <= bit_q + 4'd1;
          end else if (rx_done) begin
            if (!ack) begin
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_RX_ACK;
              unique case (role_q)
                B_ADDR:  begin rd_q <= shreg_q[0]; role_q <= B_INDEX; end
                B_INDEX: begin idx_q <= shreg_q; role_q <= B_COUNT; end
                B_COUNT: begin wcnt_q <= shreg_q; role_q <= B_DATA; end
                default: begin idx_q <= idx_q + 1'b1; wcnt_q <= wcnt_q - 8'd1; end
              endcase
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            bit_q <= 4'd0;
            if (rd_q) begin
              rd_q    <= 1'b0;
              shreg_q <= cnt_val;   // count byte leads every read
              state_q <= ST_TX;
            end else begin
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              bit_q   <= 4'd0;
              state_q <= ST_TX_ACK;
            end else begin
              shreg_q <= {shreg_q[6:0], 1'b0};
              bit_q   <= bit_q + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise && sda_s) begin
            state_q <= ST_IDLE;
          end else if (scl_fall) begin
            shreg_q <= rdata;
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  // registered one cycle behind state, so it moves only after SCL has gone low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sda_oe_q <= 1'b0;
    else         sda_oe_q <= (state_q == ST_RX_ACK) || (state_q == ST_TX && !shreg_q[7]);
  end

  assign sda_oe_o = sda_oe_q;
endmodule

// File: rtl/smb_cfg_target_chk.sv
module smb_cfg_target_chk
  import smb_cfg_pkg::*;
#(
  parameter int NUM_REGS = 15
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sda_oe_o,
  input logic                  scl_s,
  input logic                  start_s,
  input logic                  stop_s,
  input state_e                state_q,
  input logic [3:0]            bit_q,
  input logic [NUM_REGS*8-1:0] cfg_o
);
  // R1
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_release_chk: assert (!sda_oe_o);
    end
  end

  // R10
  sda_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);

  // R7
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> !sda_oe_o);

  // R11
  stop_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_s && !start_s |=> state_q == ST_IDLE);

  // R11
  start_fresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_s |=> (state_q == ST_RX) && (bit_q == 4'd0));

  // R9
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_o[14*8+7]);
endmodule

bind smb_cfg_target smb_cfg_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i, .rst_ni, .sda_oe_o, .scl_s, .start_s, .stop_s, .state_q, .bit_q, .cfg_o
);

// File: tb/smb_cfg_target_bench.sv
`timescale 1ns/1ps
module smb_cfg_target_bench;
  localparam int T = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic status = 1'b0;
  logic sda_oe;
  logic [119:0] cfg;
  logic sda_bus;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sda_bus = sda_h & ~sda_oe;

  smb_cfg_target u_smb_cfg_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .status_i(status), .cfg_o(cfg)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_of(input int k);
    return cfg[k*8 +: 8];
  endfunction

  task automatic start_cond();
    sda_h = 1'b1; #(T/2);
    scl_h = 1'b1; #(T/2);
    sda_h = 1'b0; #(T/2);
    scl_h = 1'b0; #(T/2);
  endtask

  task automatic stop_cond();
    sda_h = 1'b0; #(T/2);
    scl_h = 1'b1; #(T/2);
    sda_h = 1'b1; #T;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_h = b[i]; #T;
      scl_h = 1'b1; #T;
      scl_h = 1'b0; #(T/2);
    end
  endtask

  task automatic send_chk(input logic [7:0] b, input logic exp_ack, input string req);
    logic ack;
    send_bits(b, 8);
    sda_h = 1'b1; #T;
    scl_h = 1'b1; #(T/2);
    ack = ~sda_bus; #(T/2);
    scl_h = 1'b0; #(T/2);
    chk(req, {7'd0, ack}, {7'd0, exp_ack});
  endtask

  task automatic recv_chk(input logic [7:0] exp, input logic last, input string req);
    logic [7:0] b;
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #T;
      scl_h = 1'b1; #(T/2);
      b[i] = sda_bus; #(T/2);
      scl_h = 1'b0;
    end
    sda_h = last; #T;
    scl_h = 1'b1; #T;
    scl_h = 1'b0; #(T/2);
    sda_h = 1'b1;
    chk(req, b, exp);
  endtask

  task automatic wr_hdr(input logic [7:0] idx, input logic [7:0] cnt, input string req);
    start_cond();
    send_chk(8'hD2, 1'b1, req);
    send_chk(idx, 1'b1, req);
    send_chk(cnt, 1'b1, req);
  endtask

  task automatic rd_hdr(input logic [7:0] idx, input string req);
    start_cond();
    send_chk(8'hD2, 1'b1, req);
    send_chk(idx, 1'b1, req);
    start_cond();
    send_chk(8'hD3, 1'b1, req);
  endtask

  task automatic t_reset();
    chk("R1", {7'd0, sda_oe}, 8'h00);
    chk("R1", reg_of(8), 8'h0F);
    chk("R1", reg_of(0), 8'h00);
    chk("R1", reg_of(14), 8'h00);
  endtask

  task automatic t_write_basic();
    wr_hdr(8'd2, 8'd3, "R2");
    send_chk(8'hA1, 1'b1, "R3");
    send_chk(8'hB2, 1'b1, "R3");
    send_chk(8'hC3, 1'b1, "R3");
    stop_cond();
    chk("R3", reg_of(2), 8'hA1);
    chk("R3", reg_of(3), 8'hB2);
    chk("R3", reg_of(4), 8'hC3);
  endtask

  task automatic t_count_limit();
    wr_hdr(8'd5, 8'd1, "R4");
    send_chk(8'h11, 1'b1, "R4");
    send_chk(8'h22, 1'b0, "R4");
    stop_cond();
    chk("R4", reg_of(5), 8'h11);
    chk("R4", reg_of(6), 8'h00);
  endtask

  task automatic t_read();
    rd_hdr(8'd2, "R2");
    recv_chk(8'h0F, 1'b0, "R5");
    recv_chk(8'hA1, 1'b0, "R5");
    recv_chk(8'hB2, 1'b0, "R5");
    recv_chk(8'hC3, 1'b1, "R5");
    #T;
    chk("R7", {7'd0, sda_oe}, 8'h00);
    stop_cond();
    chk("R7", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic t_count_reg();
    wr_hdr(8'd8, 8'd1, "R6");
    send_chk(8'h04, 1'b1, "R6");
    stop_cond();
    chk("R6", reg_of(8), 8'h04);
    rd_hdr(8'd3, "R6");
    recv_chk(8'h04, 1'b0, "R6");
    recv_chk(8'hB2, 1'b1, "R6");
    stop_cond();
  endtask

  task automatic t_bad_addr();
    logic [119:0] snap;
    snap = cfg;
    start_cond();
    send_chk(8'hA4, 1'b0, "R2");
    send_chk(8'h00, 1'b0, "R2");
    send_chk(8'h5A, 1'b0, "R2");
    stop_cond();
    checks++;
    if (cfg !== snap) begin
      fails++;
      $display("FAIL R2: actual %h expected %h", cfg, snap);
    end
  endtask

  task automatic t_high_index();
    wr_hdr(8'd14, 8'd3, "R8");
    send_chk(8'hFF, 1'b1, "R8");
    send_chk(8'h55, 1'b1, "R8");
    send_chk(8'h66, 1'b1, "R8");
    stop_cond();
    chk("R9", reg_of(14), 8'h7F);
    chk("R8", reg_of(0), 8'h00);
    rd_hdr(8'd14, "R8");
    recv_chk(8'h04, 1'b0, "R8");
    recv_chk(8'h7F, 1'b0, "R9");
    recv_chk(8'h00, 1'b0, "R8");
    recv_chk(8'h00, 1'b1, "R8");
    stop_cond();
  endtask

  task automatic t_readonly();
    status = 1'b1;
    wr_hdr(8'd10, 8'd1, "R9");
    send_chk(8'hFF, 1'b1, "R9");
    stop_cond();
    rd_hdr(8'd10, "R9");
    recv_chk(8'h04, 1'b0, "R9");
    recv_chk(8'hFF, 1'b1, "R9");
    stop_cond();
    status = 1'b0;
    #T;
    chk("R9", reg_of(10), 8'hDF);
    rd_hdr(8'd10, "R9");
    recv_chk(8'h04, 1'b0, "R9");
    recv_chk(8'hDF, 1'b1, "R9");
    stop_cond();
  endtask

  task automatic t_abort();
    wr_hdr(8'd0, 8'd2, "R11");
    send_chk(8'h5A, 1'b1, "R11");
    send_bits(8'h33, 4);
    stop_cond();
    chk("R11", reg_of(0), 8'h5A);
    chk("R11", reg_of(1), 8'h00);
    wr_hdr(8'd1, 8'd1, "R11");
    send_chk(8'h77, 1'b1, "R11");
    stop_cond();
    chk("R11", reg_of(1), 8'h77);
    wr_hdr(8'd0, 8'd2, "R11");
    send_chk(8'h01, 1'b1, "R11");
    start_cond();
    send_chk(8'hD2, 1'b1, "R11");
    send_chk(8'd6, 1'b1, "R11");
    send_chk(8'd1, 1'b1, "R11");
    send_chk(8'h99, 1'b1, "R11");
    stop_cond();
    chk("R11", reg_of(0), 8'h01);
    chk("R11", reg_of(1), 8'h77);
    chk("R11", reg_of(6), 8'h99);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_basic();
    t_count_limit();
    t_read();
    t_count_reg();
    t_bad_addr();
    t_high_index();
    t_readonly();
    t_abort();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc == 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule